// File: doc/BRIEF.md
# Self-Timed Busy and Power-Mode Sequencer

This block keeps track of what a serial memory device is doing on its own after a command has been committed. The device can be in one of four places: standby, busy with a self-timed write or erase, asleep in deep power-down, or waking up from it. A command engine sends one single-cycle pulse per committed command, together with a 3-bit operation code. The sequencer decides whether the command is taken, starts the matching timed interval, and reports a write-in-progress flag. It also reports a gate that blocks array access and the current power state.

Each self-timed interval is a parameter counted in system clock cycles: data write, status write, page erase, sector erase, chip erase and wake-up release. Once a busy interval starts it runs to its end, and nothing at the command input can shorten or restart it. When a write, erase or status write finishes, the block pulses a request to clear the write enable latch. In deep power-down only the signature-read command is taken. It begins the release interval, after which the block returns to standby.

All pins are plain control and status signals. The command input is a fire-and-forget pulse with no back-pressure. The engine learns whether a command was taken from `cmd_taken`, one cycle after the pulse.

Top module: `pwrseq_top`

## Requirements
- R1: After reset, pwr_state is 00 (standby) and wip, array_block, wel_clear and cmd_taken are all 0.
- R2: In standby, a commit with cmd_op 1 (data write) or 5 (status write) raises wip and sets pwr_state to 01 (busy) from the next cycle, for exactly WRITE_CYC or SRWR_CYC cycles respectively.
- R3: In standby, a commit with cmd_op 2 (page erase), 3 (sector erase) or 4 (chip erase) holds wip high for exactly PERASE_CYC, SERASE_CYC or CERASE_CYC cycles, starting the next cycle.
- R4: While busy, every commit is ignored, including cmd_op 7: cmd_taken stays 0 and the interval length does not change.
- R5: In the first cycle after wip falls, wel_clear is high for exactly one cycle, and pwr_state is 00.
- R6: In standby, a commit with cmd_op 6 (sleep) sets pwr_state to 10 (deep power-down) from the next cycle, with wip low.
- R7: In deep power-down, a commit with any cmd_op other than 7 is ignored: cmd_taken stays 0 and pwr_state stays 10.
- R8: In deep power-down, a commit with cmd_op 7 (signature read) is taken and sets pwr_state to 11 (waking) for exactly REL_CYC cycles, then 00.
- R9: In standby, every commit (cmd_op 0, other commands, included) gives a one-cycle cmd_taken pulse in the next cycle; cmd_op 0 and cmd_op 7 leave pwr_state at 00.
- R10: While waking, every commit is ignored: cmd_taken stays 0 and the release count is unaffected.
- R11: array_block is high exactly when pwr_state is not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle pulse: a command was committed |
| cmd_op | input | 3 | Operation code of the committed command |
| wip | output | 1 | Write or erase in progress |
| array_block | output | 1 | Array reads and writes must be refused |
| pwr_state | output | 2 | 00 standby, 01 busy, 10 deep power-down, 11 waking |
| wel_clear | output | 1 | One-cycle request to clear the write enable latch |
| cmd_taken | output | 1 | The previous cycle's commit was accepted |

## Verification
A wrong mode register shows on pwr_state and array_block in the cycle right after the commit that moved it. A wrong or reloaded interval counter stays hidden until wip falls early or late. For a chip erase that is up to CERASE_CYC cycles later. Lost filtering in deep power-down or in the busy or waking states shows at once as a stray cmd_taken pulse. A misplaced latch-clear pulse shows as wel_clear out of step with the falling edge of wip.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    PS_STANDBY = 2'b00,
    PS_BUSY    = 2'b01,
    PS_DEEP    = 2'b10,
    PS_WAKE    = 2'b11
  } pstate_t;

  typedef enum logic [2:0] {
    OP_OTHER   = 3'd0,
    OP_DWRITE  = 3'd1,
    OP_PERASE  = 3'd2,
    OP_SERASE  = 3'd3,
    OP_CERASE  = 3'd4,
    OP_SRWRITE = 3'd5,
    OP_SLEEP   = 3'd6,
    OP_SIGREAD = 3'd7
  } op_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwrseq_filter.sv
module pwrseq_filter
  import pwrseq_pkg::*;
#(
  parameter int WRITE_CYC  = 40,
  parameter int SRWR_CYC   = 30,
  parameter int PERASE_CYC = 60,
  parameter int SERASE_CYC = 200,
  parameter int CERASE_CYC = 400,
  parameter int REL_CYC    = 12,
  parameter int CNT_W      = 9
) (
  input  pstate_t            state,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  output logic               accept,
  output logic               enter_busy,
  output logic               enter_deep,
  output logic               enter_wake,
  output logic [CNT_W-1:0]   load_val
);

  localparam logic [CNT_W-1:0] LD_WRITE  = CNT_W'(WRITE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SRWR   = CNT_W'(SRWR_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PERASE = CNT_W'(PERASE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SERASE = CNT_W'(SERASE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_CERASE = CNT_W'(CERASE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_REL    = CNT_W'(REL_CYC - 1);

  op_t op;
  assign op = op_t'(cmd_op);

  always_comb begin
    accept     = 1'b0;
    enter_busy = 1'b0;
    enter_deep = 1'b0;
    enter_wake = 1'b0;
    load_val   = '0;
    unique case (state)
      PS_STANDBY: begin
        accept = cmd_valid;
        if (cmd_valid) begin
          unique case (op)
            OP_DWRITE:  begin enter_busy = 1'b1; load_val = LD_WRITE;  end
            OP_SRWRITE: begin enter_busy = 1'b1; load_val = LD_SRWR;   end
            OP_PERASE:  begin enter_busy = 1'b1; load_val = LD_PERASE; end
            OP_SERASE:  begin enter_busy = 1'b1; load_val = LD_SERASE; end
            OP_CERASE:  begin enter_busy = 1'b1; load_val = LD_CERASE; end
            OP_SLEEP:   enter_deep = 1'b1;
            default:    ;
          endcase
        end
      end
      PS_DEEP: begin
        if (cmd_valid && op == OP_SIGREAD) begin
          accept     = 1'b1;
          enter_wake = 1'b1;
          load_val   = LD_REL;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;
  logic             active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= load_val;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign expire = active && (cnt == '0);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    accept,
  input  logic    enter_busy,
  input  logic    enter_deep,
  input  logic    enter_wake,
  input  logic    expire,
  output pstate_t state,
  output logic    wel_clear,
  output logic    cmd_taken
);

  pstate_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PS_STANDBY: begin
        if (enter_busy)      nxt = PS_BUSY;
        else if (enter_deep) nxt = PS_DEEP;
      end
      PS_BUSY: if (expire)     nxt = PS_STANDBY;
      PS_DEEP: if (enter_wake) nxt = PS_WAKE;
      PS_WAKE: if (expire)     nxt = PS_STANDBY;
      default: nxt = PS_STANDBY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= PS_STANDBY;
      wel_clear <= 1'b0;
      cmd_taken <= 1'b0;
    end else begin
      state     <= nxt;
      wel_clear <= (state == PS_BUSY) && expire;
      cmd_taken <= accept;
    end
  end

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int WRITE_CYC  = 40,
  parameter int SRWR_CYC   = 30,
  parameter int PERASE_CYC = 60,
  parameter int SERASE_CYC = 200,
  parameter int CERASE_CYC = 400,
  parameter int REL_CYC    = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  output logic       wip,
  output logic       array_block,
  output logic [1:0] pwr_state,
  output logic       wel_clear,
  output logic       cmd_taken
);

  localparam int MAX_CYC = max_of(max_of(max_of(WRITE_CYC, SRWR_CYC),
                                         max_of(PERASE_CYC, SERASE_CYC)),
                                  max_of(CERASE_CYC, REL_CYC));
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  pstate_t          state;
  logic             accept, enter_busy, enter_deep, enter_wake, expire;
  logic [CNT_W-1:0] load_val;

  pwrseq_filter #(
    .WRITE_CYC(WRITE_CYC), .SRWR_CYC(SRWR_CYC), .PERASE_CYC(PERASE_CYC),
    .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC), .REL_CYC(REL_CYC),
    .CNT_W(CNT_W)
  ) u_filter (
    .state(state), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .accept(accept), .enter_busy(enter_busy), .enter_deep(enter_deep),
    .enter_wake(enter_wake), .load_val(load_val)
  );

  pwrseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(enter_busy | enter_wake),
    .load_val(load_val), .expire(expire)
  );

  pwrseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .enter_busy(enter_busy),
    .enter_deep(enter_deep), .enter_wake(enter_wake), .expire(expire),
    .state(state), .wel_clear(wel_clear), .cmd_taken(cmd_taken)
  );

  assign pwr_state   = state;
  assign wip         = (state == PS_BUSY);
  assign array_block = (state != PS_STANDBY);

endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker #(
  parameter int REL_CYC = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       wip,
  input logic       array_block,
  input logic [1:0] pwr_state,
  input logic       wel_clear,
  input logic       cmd_taken
);

  int wake_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                 wake_run <= 0;
    else if (pwr_state == 2'b11) wake_run <= wake_run + 1;
    else                        wake_run <= 0;
  end

  assert_write_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd5) && pwr_state == 2'b00)
      |=> (wip && pwr_state == 2'b01));

  assert_erase_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op >= 3'd2 && cmd_op <= 3'd4 && pwr_state == 2'b00) |=> wip);

  assert_busy_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b01 && cmd_valid) |=> !cmd_taken);

  assert_clear_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (wel_clear && pwr_state == 2'b00));

  assert_clear_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clear |=> !wel_clear);

  assert_sleep_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd6 && pwr_state == 2'b00) |=> (pwr_state == 2'b10 && !wip));

  assert_deep_filters_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b10 && cmd_valid && cmd_op != 3'd7)
      |=> (pwr_state == 2'b10 && !cmd_taken));

  assert_deep_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b10 && cmd_valid && cmd_op == 3'd7)
      |=> (pwr_state == 2'b11 && cmd_taken));

  assert_wake_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_run <= REL_CYC);

  assert_wake_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b11 && cmd_valid) |=> !cmd_taken);

  assert_block_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    array_block == (pwr_state != 2'b00));

endmodule

bind pwrseq_top pwrseq_checker #(.REL_CYC(REL_CYC)) u_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .wip(wip), .array_block(array_block), .pwr_state(pwr_state),
  .wel_clear(wel_clear), .cmd_taken(cmd_taken)
);

// File: tb/pwrseq_top_test.sv
`timescale 1ns/1ps
module pwrseq_top_test;

  localparam int D_WR = 40, D_SR = 30, D_PE = 60, D_SE = 200, D_CE = 400, D_REL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic wip, array_block, wel_clear, cmd_taken;
  logic [1:0] pwr_state;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwrseq_top #(
    .WRITE_CYC(D_WR), .SRWR_CYC(D_SR), .PERASE_CYC(D_PE),
    .SERASE_CYC(D_SE), .CERASE_CYC(D_CE), .REL_CYC(D_REL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .wip(wip), .array_block(array_block), .pwr_state(pwr_state),
    .wel_clear(wel_clear), .cmd_taken(cmd_taken)
  );

  // behavioural reference: mode 0 standby, 1 busy, 2 asleep, 3 waking
  int m_mode = 0;
  int m_left = 0;
  bit m_wel = 0;
  bit m_take = 0;

  function automatic int dur_of(input int op);
    case (op)
      1: return D_WR;
      2: return D_PE;
      3: return D_SE;
      4: return D_CE;
      5: return D_SR;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    started <= 1'b1;
    if (!rst_n) begin
      m_mode <= 0; m_left <= 0; m_wel <= 0; m_take <= 0;
    end else begin
      m_wel  <= 0;
      m_take <= 0;
      if (m_mode == 0) begin
        if (cmd_valid) begin
          m_take <= 1;
          if (cmd_op >= 1 && cmd_op <= 5) begin
            m_mode <= 1; m_left <= dur_of(int'(cmd_op));
          end else if (cmd_op == 6) m_mode <= 2;
        end
      end else if (m_mode == 1) begin
        if (m_left == 1) begin m_mode <= 0; m_wel <= 1; end
        m_left <= m_left - 1;
      end else if (m_mode == 2) begin
        if (cmd_valid && cmd_op == 7) begin
          m_take <= 1; m_mode <= 3; m_left <= D_REL;
        end
      end else begin
        if (m_left == 1) m_mode <= 0;
        m_left <= m_left - 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done && rst_n) begin
      chk("R2 R3 R4 wip", int'(wip), (m_mode == 1) ? 1 : 0);
      chk("R6 R7 R8 R10 pwr_state", int'(pwr_state), m_mode);
      chk("R11 array_block", int'(array_block), (m_mode != 0) ? 1 : 0);
      chk("R5 wel_clear", int'(wel_clear), int'(m_wel));
      chk("R9 R4 R7 R10 cmd_taken", int'(cmd_taken), int'(m_take));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int op);
    cmd_valid = 1'b1;
    cmd_op = 3'(op);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op = 3'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwr_state", int'(pwr_state), 0);
    chk("R1 wip", int'(wip), 0);
    chk("R1 flags", int'({array_block, wel_clear, cmd_taken}), 0);
    // R9 plain command and signature read in standby
    send(0); idle(2);
    send(7); idle(2);
    // R2 data write, with commits while busy (R4)
    send(1); idle(5); send(7); idle(3); send(1); idle(3); send(6);
    idle(D_WR);
    // R2 status write, then back-to-back write right at completion
    send(5); idle(D_SR - 1);
    send(1); idle(D_WR + 3);
    // R3 erases
    send(2); idle(D_PE + 2);
    send(3); idle(20); send(4); idle(D_SE);
    send(4); idle(D_CE + 2);
    // R6 sleep, R7 filtering, R8 wake, R10 commits while waking
    send(6); idle(3);
    send(1); send(0); send(4); send(6); idle(2);
    send(7); idle(2); send(1); send(7); send(6); idle(D_REL + 2);
    // immediate sleep and wake
    send(6); send(7); idle(D_REL + 2);
    send(5); idle(D_SR + 2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule